// File: doc/BRIEF.md
# LIN Break Detector and Generator

This block adds break handling for a LIN bus to a serial transmitter and receiver that already advance one bit time per baud tick. On the receive side it counts consecutive dominant (low) bit-time samples of the synchronized line. It raises a one-cycle flag once the run reaches a threshold that depends on the mode. The threshold is set high enough that a 0x00 data character, stretched by up to ±15 % clock mismatch between nodes, never passes for a break.

On the transmit side, a request forces the line dominant for a mode-dependent number of bit times. One recessive delimiter bit follows. The request waits while the existing transmitter is still shifting a character or while an earlier break is still running. Three control inputs select the mode: LIN transmit enable, LIN receive enable, and a length-select bit. With both enables clear, the block falls back to the ordinary ten-bit break rule.

Top module: `lin_brk_top`

## Requirements
- R1: With `lin_tx_en` and `lin_rx_en` both 0, a break is flagged after 10 dominant bit ticks and a requested break is 10 bit times long, for either value of `lin_len_sel`.
- R2: With `lin_rx_en`=1 and `lin_len_sel`=0, `brk_flag` pulses only once 11 consecutive dominant bit ticks have been sampled.
- R3: With `lin_rx_en`=1 and `lin_len_sel`=1, `brk_flag` pulses only once 12 consecutive dominant bit ticks have been sampled.
- R4: With `lin_tx_en`=1, a requested break drives `tx_out` low for 13 bit times when `lin_len_sel`=0 and for 14 when `lin_len_sel`=1.
- R5: With both enables set, detection (11 or 12) and generation (13 or 14) run together, and `lin_len_sel` picks the pair.
- R6: With `lin_rx_en`=1, a dominant run of 10 bit ticks, which is the longest a stretched 0x00 character can last, never raises `brk_flag`.
- R7: `brk_flag` is high for one cycle per dominant run. A recessive sample clears the run count and re-arms the flag.
- R8: After a break, `tx_out` follows `tx_data_in` (recessive) for one full bit time before `tx_busy` falls.
- R9: A request made while `char_active` is high, or while a break is in progress, is held with `tx_busy` high. It starts on a bit tick after the current transmission ends, with at least one recessive bit time before it.
- R10: `rx_in` passes through a two-flop synchronizer. Reset clears the run count and the flag, and returns the transmitter to idle: `tx_busy`=0 and `tx_out`=`tx_data_in`.
- R11: Outside a break, `tx_out` equals `tx_data_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| lin_tx_en | input | 1 | LIN break generation enable |
| lin_rx_en | input | 1 | LIN break detection enable |
| lin_len_sel | input | 1 | Length select: 0 gives 11/13, 1 gives 12/14 |
| rx_in | input | 1 | Asynchronous receive line |
| brk_flag | output | 1 | One-cycle break-detected pulse |
| brk_req | input | 1 | Break request pulse |
| char_active | input | 1 | Existing transmitter is sending a character |
| tx_data_in | input | 1 | Line level from the existing transmitter |
| tx_out | output | 1 | Line level driven to the bus |
| tx_busy | output | 1 | Break pending, in progress or in delimiter |

## Verification
The hardest case to reach is a break request that arrives while another break is already driving the line, since the queued request only matters during the delimiter handoff. The stimulus waits until `tx_out` has been low for several cycles and then pulses `brk_req` from inside the measurement loop. It then checks three things: `tx_busy` never drops in the gap, the gap lasts between one and two bit times, and the second break has full length. Detection boundaries are tested by placing the last dominant tick exactly one short of each threshold and then exactly on it.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;

  typedef enum logic [1:0] {
    GEN_IDLE  = 2'd0,
    GEN_LOW   = 2'd1,
    GEN_DELIM = 2'd2
  } gen_state_e;

  // Dominant-run length that counts as a break on receive.
  function automatic int unsigned rx_threshold(logic lin_rx, logic long_sel,
                                               int unsigned norm_bits,
                                               int unsigned lin_bits);
    return lin_rx ? (lin_bits + (long_sel ? 32'd1 : 32'd0)) : norm_bits;
  endfunction

  // Number of dominant bit times driven for a requested break.
  function automatic int unsigned tx_length(logic lin_tx, logic long_sel,
                                            int unsigned norm_bits,
                                            int unsigned lin_bits);
    return lin_tx ? (lin_bits + (long_sel ? 32'd1 : 32'd0)) : norm_bits;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/lin_brk_sync.sv
module lin_brk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/lin_brk_detect.sv
module lin_brk_detect
  import lin_brk_pkg::*;
#(
  parameter int unsigned NORM_BITS = 10,
  parameter int unsigned LIN_BITS  = 11,
  parameter int unsigned CNT_W     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic rx_s,
  input  logic lin_rx_en,
  input  logic len_sel,
  output logic brk_flag
);
  logic [CNT_W-1:0] run_cnt;
  logic             fired;
  logic [CNT_W:0]   thr_ext;
  logic [CNT_W:0]   cnt_inc;
  logic             cnt_sat;
  logic             dom_tick;
  logic             run_hit;

  assign thr_ext  = (CNT_W+1)'(rx_threshold(lin_rx_en, len_sel, NORM_BITS, LIN_BITS));
  assign cnt_inc  = {1'b0, run_cnt} + 1'b1;
  assign cnt_sat  = &run_cnt;
  assign dom_tick = bit_tick && !rx_s;
  assign run_hit  = dom_tick && !fired && (cnt_inc == thr_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      fired    <= 1'b0;
      brk_flag <= 1'b0;
    end else if (rx_s) begin
      run_cnt  <= '0;
      fired    <= 1'b0;
      brk_flag <= 1'b0;
    end else begin
      brk_flag <= run_hit;
      if (run_hit) fired <= 1'b1;
      if (dom_tick && !cnt_sat) run_cnt <= run_cnt + 1'b1;
    end
  end

  // R7: a flag only follows a dominant bit tick
  p_flag_dominant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_flag |-> $past(dom_tick));
  // R7: the flag never lasts two cycles
  p_flag_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_flag |=> !brk_flag);
  // R7: a recessive sample empties the run counter
  p_run_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_s |=> (run_cnt == '0));
  // R6: in LIN receive mode no flag before the eleventh dominant tick
  p_no_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_flag && $past(lin_rx_en)) |-> ($past(run_cnt) >= CNT_W'(LIN_BITS - 1)));
endmodule

// File: rtl/lin_brk_gen.sv
module lin_brk_gen
  import lin_brk_pkg::*;
#(
  parameter int unsigned NORM_BITS  = 10,
  parameter int unsigned LIN_BITS   = 13,
  parameter int unsigned DELIM_BITS = 1,
  parameter int unsigned CNT_W      = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic lin_tx_en,
  input  logic len_sel,
  input  logic brk_req,
  input  logic char_active,
  input  logic tx_data_in,
  output logic tx_out,
  output logic tx_busy
);
  gen_state_e       st;
  logic [CNT_W-1:0] bit_cnt;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] gen_len;
  logic             pend;
  logic             start_low;
  logic             low_done;
  logic             delim_done;
  logic             in_low;

  assign gen_len    = CNT_W'(tx_length(lin_tx_en, len_sel, NORM_BITS, LIN_BITS));
  assign start_low  = (st == GEN_IDLE) && pend && !char_active && bit_tick;
  assign low_done   = (st == GEN_LOW) && bit_tick && (bit_cnt == len_q - 1'b1);
  assign delim_done = (st == GEN_DELIM) && bit_tick && (bit_cnt == CNT_W'(DELIM_BITS - 1));
  assign in_low     = (st == GEN_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= GEN_IDLE;
      bit_cnt <= '0;
      len_q   <= '0;
      pend    <= 1'b0;
    end else begin
      if (start_low)    pend <= brk_req;
      else if (brk_req) pend <= 1'b1;

      unique case (st)
        GEN_IDLE: begin
          if (start_low) begin
            st      <= GEN_LOW;
            bit_cnt <= '0;
            len_q   <= gen_len;
          end
        end
        GEN_LOW: begin
          if (low_done) begin
            st      <= GEN_DELIM;
            bit_cnt <= '0;
          end else if (bit_tick) begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        GEN_DELIM: begin
          if (delim_done) begin
            st      <= GEN_IDLE;
            bit_cnt <= '0;
          end else if (bit_tick) begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        default: st <= GEN_IDLE;
      endcase
    end
  end

  assign tx_out  = in_low ? 1'b0 : tx_data_in;
  assign tx_busy = pend || (st != GEN_IDLE);

  // R8: busy only ends out of the delimiter
  p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> ($past(st) == GEN_DELIM));
  // R9: a break never starts over a character
  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_low) |-> $past(!char_active));
  // R4: the latched length holds for the whole break
  p_len_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_low && $past(in_low)) |-> $stable(len_q));
  // R4: the bit counter stays inside the latched length
  p_len_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_low |-> (bit_cnt < len_q));
endmodule

// File: rtl/lin_brk_top.sv
module lin_brk_top
  import lin_brk_pkg::*;
#(
  parameter int unsigned NORM_BITS    = 10,
  parameter int unsigned LIN_DET_BITS = 11,
  parameter int unsigned LIN_GEN_BITS = 13,
  parameter int unsigned DELIM_BITS   = 1,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic lin_tx_en,
  input  logic lin_rx_en,
  input  logic lin_len_sel,
  input  logic rx_in,
  output logic brk_flag,
  input  logic brk_req,
  input  logic char_active,
  input  logic tx_data_in,
  output logic tx_out,
  output logic tx_busy
);
  localparam int unsigned MAX_LEN = max3(NORM_BITS, LIN_DET_BITS + 1, LIN_GEN_BITS + 1);
  localparam int unsigned CNT_W   = $clog2(max3(MAX_LEN, DELIM_BITS, 1) + 1);

  logic rx_s;

  lin_brk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (rx_in),
    .q_sync  (rx_s)
  );

  lin_brk_detect #(
    .NORM_BITS (NORM_BITS),
    .LIN_BITS  (LIN_DET_BITS),
    .CNT_W     (CNT_W)
  ) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .rx_s      (rx_s),
    .lin_rx_en (lin_rx_en),
    .len_sel   (lin_len_sel),
    .brk_flag  (brk_flag)
  );

  lin_brk_gen #(
    .NORM_BITS  (NORM_BITS),
    .LIN_BITS   (LIN_GEN_BITS),
    .DELIM_BITS (DELIM_BITS),
    .CNT_W      (CNT_W)
  ) u_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_tick    (bit_tick),
    .lin_tx_en   (lin_tx_en),
    .len_sel     (lin_len_sel),
    .brk_req     (brk_req),
    .char_active (char_active),
    .tx_data_in  (tx_data_in),
    .tx_out      (tx_out),
    .tx_busy     (tx_busy)
  );
endmodule

// File: tb/lin_brk_top_tb.sv
`timescale 1ns/1ps
module lin_brk_top_tb_top;
  localparam int DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0, bit_tick = 1'b0;
  logic lin_tx_en = 1'b0, lin_rx_en = 1'b0, lin_len_sel = 1'b0;
  logic rx_in = 1'b1, brk_req = 1'b0, char_active = 1'b0, tx_data_in = 1'b1;
  logic brk_flag, tx_out, tx_busy;

  int errors = 0, checks = 0, cyc = 0, flag_pulses = 0;
  bit finished = 1'b0;

  lin_brk_top dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .lin_tx_en(lin_tx_en), .lin_rx_en(lin_rx_en), .lin_len_sel(lin_len_sel),
    .rx_in(rx_in), .brk_flag(brk_flag), .brk_req(brk_req),
    .char_active(char_active), .tx_data_in(tx_data_in),
    .tx_out(tx_out), .tx_busy(tx_busy)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    bit_tick = (cyc % DIV == 0);
  end

  always @(posedge clk) if (brk_flag) flag_pulses++;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic wait_ticks(int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!bit_tick);
    end
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  // Receive: flag exactly at thr dominant ticks, once per run
  task automatic t_detect(logic txe, logic rxe, logic sel, int thr, string tag);
    lin_tx_en = txe; lin_rx_en = rxe; lin_len_sel = sel;
    wait_ticks(1); @(negedge clk); rx_in = 1'b0; flag_pulses = 0;
    wait_ticks(thr - 1); settle();
    chk(flag_pulses == 0, tag, "flag before threshold", flag_pulses, 0);
    wait_ticks(1); settle();
    chk(flag_pulses == 1, tag, "flag at threshold", flag_pulses, 1);
    wait_ticks(3); settle();
    chk(flag_pulses == 1, tag, "no retrigger in run (R7)", flag_pulses, 1);
    rx_in = 1'b1; wait_ticks(2); settle();
  endtask

  // Transmit: measure break length and delimiter
  task automatic t_gen(logic txe, logic rxe, logic sel, int len, string tag);
    int lowc, delc, w;
    lin_tx_en = txe; lin_rx_en = rxe; lin_len_sel = sel;
    @(negedge clk); brk_req = 1'b1; @(negedge clk); brk_req = 1'b0;
    w = 0;
    while (tx_out && w < 100) begin w++; @(negedge clk); end
    lowc = 0;
    while (!tx_out && lowc < 200) begin lowc++; @(negedge clk); end
    chk(lowc == len * DIV, tag, "break low cycles", lowc, len * DIV);
    delc = 0;
    while (tx_busy && delc < 200) begin delc++; @(negedge clk); end
    chk(delc == DIV, tag, "delimiter cycles before idle (R8)", delc, DIV);
  endtask

  task automatic t_stretch();
    lin_tx_en = 1'b0; lin_rx_en = 1'b1; lin_len_sel = 1'b0;
    wait_ticks(1); @(negedge clk); rx_in = 1'b0; flag_pulses = 0;
    wait_ticks(10); settle();
    chk(flag_pulses == 0, "R6", "10-tick dominant run", flag_pulses, 0);
    rx_in = 1'b1; wait_ticks(1); @(negedge clk); rx_in = 1'b0;
    wait_ticks(10); settle();
    chk(flag_pulses == 0, "R7", "count cleared by recessive tick", flag_pulses, 0);
    rx_in = 1'b1; wait_ticks(2); settle();
  endtask

  task automatic t_rearm();
    lin_tx_en = 1'b0; lin_rx_en = 1'b1; lin_len_sel = 1'b0;
    wait_ticks(1); @(negedge clk); rx_in = 1'b0; flag_pulses = 0;
    wait_ticks(11); settle();
    rx_in = 1'b1; wait_ticks(1); @(negedge clk); rx_in = 1'b0;
    wait_ticks(11); settle();
    chk(flag_pulses == 2, "R7", "re-armed after recessive", flag_pulses, 2);
    rx_in = 1'b1; wait_ticks(2); settle();
  endtask

  task automatic t_hold_char();
    int lowc;
    lin_tx_en = 1'b1; lin_rx_en = 1'b0; lin_len_sel = 1'b0;
    char_active = 1'b1;
    @(negedge clk); brk_req = 1'b1; @(negedge clk); brk_req = 1'b0;
    repeat (20) @(negedge clk);
    chk(tx_out == 1'b1, "R9", "line held during character", int'(tx_out), 1);
    chk(tx_busy == 1'b1, "R9", "busy while request pending", int'(tx_busy), 1);
    char_active = 1'b0;
    lowc = 0;
    while (tx_out && lowc < 100) begin lowc++; @(negedge clk); end
    lowc = 0;
    while (!tx_out && lowc < 200) begin lowc++; @(negedge clk); end
    chk(lowc == 13 * DIV, "R9", "held break length", lowc, 13 * DIV);
    while (tx_busy && lowc < 400) begin lowc++; @(negedge clk); end
  endtask

  task automatic t_back_to_back();
    int lowc, gap, w;
    bit busy_gap;
    lin_tx_en = 1'b1; lin_rx_en = 1'b0; lin_len_sel = 1'b1;
    @(negedge clk); brk_req = 1'b1; @(negedge clk); brk_req = 1'b0;
    w = 0;
    while (tx_out && w < 100) begin w++; @(negedge clk); end
    lowc = 0;
    while (!tx_out && lowc < 200) begin
      lowc++;
      brk_req = (lowc == 5);
      @(negedge clk);
    end
    brk_req = 1'b0;
    chk(lowc == 14 * DIV, "R4", "first break length", lowc, 14 * DIV);
    gap = 0; busy_gap = 1'b1;
    while (tx_out && gap < 200) begin
      gap++;
      if (!tx_busy) busy_gap = 1'b0;
      @(negedge clk);
    end
    chk(gap >= DIV && gap <= 2 * DIV, "R9", "gap between breaks", gap, DIV);
    chk(busy_gap, "R9", "busy through gap", int'(busy_gap), 1);
    lowc = 0;
    while (!tx_out && lowc < 200) begin lowc++; @(negedge clk); end
    chk(lowc == 14 * DIV, "R9", "queued break length", lowc, 14 * DIV);
    w = 0;
    while (tx_busy && w < 200) begin w++; @(negedge clk); end
    chk(w == DIV, "R8", "delimiter after queued break", w, DIV);
  endtask

  task automatic t_follow();
    @(negedge clk); tx_data_in = 1'b0; #1;
    chk(tx_out == 1'b0, "R11", "idle line follows data 0", int'(tx_out), 0);
    @(negedge clk); tx_data_in = 1'b1; #1;
    chk(tx_out == 1'b1, "R11", "idle line follows data 1", int'(tx_out), 1);
  endtask

  task automatic t_reset_mid();
    int w;
    lin_tx_en = 1'b1; lin_rx_en = 1'b1; lin_len_sel = 1'b0;
    @(negedge clk); brk_req = 1'b1; @(negedge clk); brk_req = 1'b0;
    w = 0;
    while (tx_out && w < 100) begin w++; @(negedge clk); end
    repeat (6) @(negedge clk);
    rst_n = 1'b0; #1;
    chk(tx_out == tx_data_in, "R10", "tx_out after reset", int'(tx_out), int'(tx_data_in));
    chk(tx_busy == 1'b0, "R10", "busy after reset", int'(tx_busy), 0);
    chk(brk_flag == 1'b0, "R10", "flag after reset", int'(brk_flag), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(brk_flag == 1'b0, "R10", "flag in reset", int'(brk_flag), 0);
    chk(tx_busy == 1'b0, "R10", "busy in reset", int'(tx_busy), 0);
    chk(tx_out == 1'b1, "R10", "line recessive in reset", int'(tx_out), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    t_detect(1'b0, 1'b0, 1'b0, 10, "R1");
    t_detect(1'b0, 1'b0, 1'b1, 10, "R1");
    t_gen(1'b0, 1'b0, 1'b0, 10, "R1");
    t_gen(1'b0, 1'b0, 1'b1, 10, "R1");
    t_detect(1'b0, 1'b1, 1'b0, 11, "R2");
    t_detect(1'b0, 1'b1, 1'b1, 12, "R3");
    t_gen(1'b1, 1'b0, 1'b0, 13, "R4");
    t_gen(1'b1, 1'b0, 1'b1, 14, "R4");
    t_detect(1'b1, 1'b1, 1'b0, 11, "R5");
    t_gen(1'b1, 1'b1, 1'b0, 13, "R5");
    t_detect(1'b1, 1'b1, 1'b1, 12, "R5");
    t_gen(1'b1, 1'b1, 1'b1, 14, "R5");
    t_stretch();
    t_rearm();
    t_hold_char();
    t_back_to_back();
    t_follow();
    t_reset_mid();
    t_detect(1'b0, 1'b1, 1'b0, 11, "R10");

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule